// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block gathers a set of device interrupt request lines into one shared request vector. It routes that vector to up to four CPUs. Each CPU owns a mask as wide as the request vector. The block keeps a routed-status vector per CPU, equal to that CPU's mask ANDed with the shared requests. From it the block drives one registered interrupt level per CPU, which is high whenever any routed bit is set.

Devices signal events with single-cycle pulses: `dev_set[n]` raises request n and `dev_clr[n]` withdraws it. Software uses a 64-bit register port. Each access is answered one clock later with a response that carries read data or an error flag. Registers sit on 64-byte strides, and the register index is the byte offset shifted right by 6. Indices 0 to 3 are the per-CPU masks, which can be read and written. Indices 4 to 7 are the per-CPU routed-status vectors and index 8 is the shared request vector; these five are read-only.

Top module: `dev_irq_router`

## Requirements
- R1: After reset, every mask, the request vector, every routed-status vector and every `cpu_irq` bit read as zero.
- R2: A legal 8-byte write to index k (byte offset k*64, k in 0..3) stores `req_wdata` as CPU k's mask, and a read of the same index returns it. Address bits 5:0 do not select a register.
- R3: CPU k's routed-status vector (`cpu_routed[k*64 +: 64]`, readable at index 4+k) always equals CPU k's mask AND the request vector.
- R4: A pulse on `dev_set[n]` sets bit n of the request vector, which is readable at index 8. Every CPU whose mask has bit n set then gets routed bit n.
- R5: A pulse on `dev_clr[n]` clears request bit n and withdraws routed bit n from every CPU. A clear of a bit that is not set changes nothing. When set and clear arrive for the same bit in the same cycle, the set wins.
- R6: `cpu_irq[k]` is the OR of CPU k's routed-status vector. It changes at the first clock edge that samples the causing event and not earlier.
- R7: Setting a mask bit whose request is active raises that CPU's interrupt. Clearing it withdraws the interrupt for that CPU only; other CPUs are unaffected.
- R8: An access whose `req_bytes` is not 8 gets an error response and changes no state.
- R9: A write to index 4..8 (routed status or request) gets an error response and changes no state.
- R10: An access to any index above 8 gets an error response. An error response always carries zero read data.
- R11: Every access presented with `req_valid` gets exactly one response, with `rsp_valid` high in the following cycle. A legal write responds with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset; bits 9:6 form the register index |
| req_bytes | input | 4 | Access size in bytes; only 8 is legal |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Access was illegal and was discarded |
| rsp_rdata | output | 64 | Read data; zero for writes and errors |
| dev_set | input | 64 | Per-line request-raise pulses |
| dev_clr | input | 64 | Per-line request-withdraw pulses |
| cpu_irq | output | 4 | Device-interrupt level per CPU |
| cpu_routed | output | 256 | Routed-status vectors, CPU k in bits k*64+63..k*64 |

## Verification
The masks are given distinct shapes: a sparse alternating nibble pattern, a single bit, all ones and all zeros. One device event therefore reaches some CPUs and skips others, which separates per-CPU routing from a broadcast. Request pulses on the lowest, highest and middle lines expose index slips. A clear on an idle line, and a set with a clear in the same cycle, separate the ignore rule from the set-wins rule. Mask writes made while requests are pending show whether the level is recomputed on the mask side as well. Illegal sizes, read-only targets and out-of-range indices are each followed by read-back, which shows that nothing was disturbed.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam int unsigned STRIDE_LG = 6;

  typedef enum logic [1:0] {
    RK_MASK   = 2'd0,
    RK_ROUTED = 2'd1,
    RK_REQ    = 2'd2,
    RK_NONE   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/dir_decode.sv
module dir_decode
  import dir_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned BYTES   = 8,
  localparam int unsigned IDX_W  = ADDR_W - STRIDE_LG,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned BYTES_W = $clog2(BYTES) + 1
) (
  input  logic               valid_i,
  input  logic               write_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTES_W-1:0] bytes_i,
  output reg_kind_e          kind_o,
  output logic [CPU_W-1:0]   sel_o,
  output logic               err_o,
  output logic               mask_we_o
);
  logic [IDX_W-1:0] idx;
  logic             unused_low;

  assign idx        = addr_i[ADDR_W-1:STRIDE_LG];
  assign unused_low = ^addr_i[STRIDE_LG-1:0];

  always_comb begin
    kind_o = RK_NONE;
    sel_o  = '0;
    if (idx < IDX_W'(NUM_CPU)) begin
      kind_o = RK_MASK;
      sel_o  = CPU_W'(idx);
    end else if (idx < IDX_W'(2 * NUM_CPU)) begin
      kind_o = RK_ROUTED;
      sel_o  = CPU_W'(idx - IDX_W'(NUM_CPU));
    end else if (idx == IDX_W'(2 * NUM_CPU)) begin
      kind_o = RK_REQ;
    end
  end

  always_comb begin
    err_o = valid_i && ((bytes_i != BYTES_W'(BYTES)) || (kind_o == RK_NONE) ||
                        (write_i && (kind_o != RK_MASK)));
    mask_we_o = valid_i && write_i && !err_o && (kind_o == RK_MASK);
  end
endmodule

// File: rtl/dir_req_bank.sv
module dir_req_bank #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] req_n_o,
  output logic [NUM_SRC-1:0] req_q_o
);
  logic req_en;

  always_comb begin
    req_en  = |{set_i, clr_i};
    req_n_o = (req_q_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q_o <= '0;
    else if (req_en) req_q_o <= req_n_o;
  end

  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |set_i |=> (($past(set_i) & ~req_q_o) == '0));

  p_clr_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_i |=> (($past(clr_i) & ~$past(set_i) & req_q_o) == '0));
endmodule

// File: rtl/dir_cpu_lane.sv
module dir_cpu_lane #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] req_n_i,
  output logic [NUM_SRC-1:0] mask_q_o,
  output logic [NUM_SRC-1:0] routed_q_o,
  output logic               irq_q_o
);
  logic [NUM_SRC-1:0] mask_n;
  logic [NUM_SRC-1:0] routed_n;
  logic               irq_n;

  always_comb begin
    mask_n   = we_i ? wdata_i : mask_q_o;
    routed_n = mask_n & req_n_i;
    irq_n    = |routed_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q_o <= '0;
    else if (we_i) mask_q_o <= mask_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      routed_q_o <= '0;
      irq_q_o    <= 1'b0;
    end else begin
      routed_q_o <= routed_n;
      irq_q_o    <= irq_n;
    end
  end

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q_o == $past(wdata_i)));

  p_irq_is_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q_o == (|routed_q_o));
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
  import dir_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned DATA_W  = NUM_SRC,
  localparam int unsigned BYTES   = DATA_W / 8,
  localparam int unsigned BYTES_W = $clog2(BYTES) + 1,
  localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [BYTES_W-1:0]         req_bytes,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [DATA_W-1:0]          rsp_rdata,
  input  logic [NUM_SRC-1:0]         dev_set,
  input  logic [NUM_SRC-1:0]         dev_clr,
  output logic [NUM_CPU-1:0]         cpu_irq,
  output logic [NUM_CPU*NUM_SRC-1:0] cpu_routed
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  reg_kind_e          kind;
  logic [CPU_W-1:0]   sel;
  logic               acc_err;
  logic               mask_we;
  logic [NUM_SRC-1:0] req_n;
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] mask_q   [NUM_CPU];
  logic [NUM_SRC-1:0] routed_q [NUM_CPU];
  logic [NUM_CPU*NUM_SRC-1:0] mask_flat;

  dir_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .BYTES(BYTES)) u_decode (
    .valid_i  (req_valid),
    .write_i  (req_write),
    .addr_i   (req_addr),
    .bytes_i  (req_bytes),
    .kind_o   (kind),
    .sel_o    (sel),
    .err_o    (acc_err),
    .mask_we_o(mask_we)
  );

  dir_req_bank #(.NUM_SRC(NUM_SRC)) u_req (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (dev_set),
    .clr_i  (dev_clr),
    .req_n_o(req_n),
    .req_q_o(req_q)
  );

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_lane
    dir_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .we_i      (mask_we && (sel == CPU_W'(k))),
      .wdata_i   (req_wdata),
      .req_n_i   (req_n),
      .mask_q_o  (mask_q[k]),
      .routed_q_o(routed_q[k]),
      .irq_q_o   (cpu_irq[k])
    );
    assign cpu_routed[k*NUM_SRC +: NUM_SRC] = routed_q[k];
    assign mask_flat[k*NUM_SRC +: NUM_SRC]  = mask_q[k];

    p_routed_and_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      routed_q[k] == (mask_q[k] & req_q));
  end

  logic [DATA_W-1:0] rdata_n;
  logic              rsp_en;

  always_comb begin
    rdata_n = '0;
    if (req_valid && !req_write && !acc_err) begin
      unique case (kind)
        RK_MASK:   rdata_n = mask_q[sel];
        RK_ROUTED: rdata_n = routed_q[sel];
        RK_REQ:    rdata_n = req_q;
        default:   rdata_n = '0;
      endcase
    end
    rsp_en = req_valid || rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (rsp_en) begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= rdata_n;
    end
  end

  p_rsp_next_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  p_err_keeps_masks_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (mask_flat == $past(mask_flat)));

  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_rdata == '0));
endmodule

// File: tb/dev_irq_router_tb_top.sv
`timescale 1ns/1ps
module dev_irq_router_tb_top;
  localparam int NC = 4;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [9:0]    req_addr = '0;
  logic [3:0]    req_bytes = '0;
  logic [63:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic [63:0]   rsp_rdata;
  logic [NS-1:0] dev_set = '0;
  logic [NS-1:0] dev_clr = '0;
  logic [NC-1:0] cpu_irq;
  logic [NC*NS-1:0] cpu_routed;

  always #5 clk = ~clk;

  dev_irq_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dev_set(dev_set), .dev_clr(dev_clr),
    .cpu_irq(cpu_irq), .cpu_routed(cpu_routed)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NS-1:0] m_mask [NC];
  logic [NS-1:0] m_req;

  logic [64:0]  exp_q [$];
  string        tag_q [$];

  // Monitor: pops one expected response per observed response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected response err=%0b data=%h expected none", rsp_err, rsp_rdata);
      end else begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_err, rsp_rdata} !== e) begin
          fails++;
          $display("FAIL %s err/data got %0b/%h expected %0b/%h", t, rsp_err, rsp_rdata, e[64], e[63:0]);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    for (int k = 0; k < NC; k++) begin
      check({tag, " routed"}, 256'(cpu_routed[k*NS +: NS]), 256'(m_mask[k] & m_req));
      check({tag, " irq"}, 256'(cpu_irq[k]), 256'(|(m_mask[k] & m_req)));
    end
  endtask

  // Driver: one access, expected response pushed to the scoreboard.
  task automatic access(input string tag, input bit wr, input int idx, input logic [5:0] low,
                        input logic [3:0] bytes, input logic [63:0] wd);
    bit err;
    logic [63:0] d;
    err = (bytes != 4'd8) || (idx > 8) || (wr && idx >= 4);
    d = '0;
    if (!err && !wr) begin
      if (idx < 4)      d = m_mask[idx];
      else if (idx < 8) d = m_mask[idx-4] & m_req;
      else              d = m_req;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {4'(idx), low};
    req_bytes = bytes; req_wdata = wd;
    exp_q.push_back({err, d});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (!err && wr) m_mask[idx] = wd;
  endtask

  task automatic dev_pulse(input string tag, input logic [NS-1:0] s, input logic [NS-1:0] c);
    @(negedge clk);
    dev_set = s; dev_clr = c;
    @(negedge clk);
    dev_set = '0; dev_clr = '0;
    m_req = (m_req & ~c) | s;
    check_outs(tag);
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NC; k++) m_mask[k] = '0;
    m_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_outs("R1 reset");
    access("R1 mask0 after reset", 0, 0, 6'd0, 4'd8, '0);
    access("R1 req after reset", 0, 8, 6'd0, 4'd8, '0);

    // R2 mask write/read, R11 write responds with zero
    access("R2 write mask0", 1, 0, 6'd0, 4'd8, 64'hF0F0_F0F0_F0F0_F0F0);
    access("R2 write mask1", 1, 1, 6'd0, 4'd8, 64'h0000_0000_0000_0020);
    access("R2 write mask2", 1, 2, 6'd0, 4'd8, '1);
    access("R2 write mask3", 1, 3, 6'd0, 4'd8, '0);
    access("R2 read mask0", 0, 0, 6'd0, 4'd8, '0);
    access("R2 read mask1 low offset", 0, 1, 6'd8, 4'd8, '0);
    check_outs("R3 masks without requests");

    // R6 timing: level must not move before the sampling edge
    @(negedge clk);
    dev_set = 64'h20;
    #1;
    check("R6 irq before edge", 256'(cpu_irq), 256'(0));
    @(negedge clk);
    dev_set = '0;
    m_req = 64'h20;
    check_outs("R4 R6 set line 5");

    dev_pulse("R4 set lines 0 and 63", 64'h8000_0000_0000_0001, '0);
    access("R4 read req", 0, 8, 6'd0, 4'd8, '0);
    access("R3 read routed0", 0, 4, 6'd0, 4'd8, '0);
    access("R3 read routed2", 0, 6, 6'd0, 4'd8, '0);

    // R7 mask side changes
    access("R7 raise cpu3", 1, 3, 6'd0, 4'd8, 64'h1);
    check_outs("R7 after raising cpu3");
    access("R7 withdraw cpu1", 1, 1, 6'd0, 4'd8, '0);
    check_outs("R7 after withdrawing cpu1");

    // R5 clears
    dev_pulse("R5 clear line 5", '0, 64'h20);
    dev_pulse("R5 clear idle line 10", '0, 64'h400);
    access("R5 req after idle clear", 0, 8, 6'd0, 4'd8, '0);
    dev_pulse("R5 set wins line 20", 64'h10_0000, 64'h10_0000);
    dev_pulse("R5 clear line 0", '0, 64'h1);

    // R8 bad size
    access("R8 write size 4", 1, 0, 6'd0, 4'd4, 64'h1234);
    access("R8 read size 1", 0, 5, 6'd0, 4'd1, '0);
    access("R8 mask0 unchanged", 0, 0, 6'd0, 4'd8, '0);
    check_outs("R8 outputs unchanged");

    // R9 read-only targets
    access("R9 write routed1", 1, 5, 6'd0, 4'd8, '1);
    access("R9 write req", 1, 8, 6'd0, 4'd8, '0);
    access("R9 req unchanged", 0, 8, 6'd0, 4'd8, '0);
    access("R9 routed1 unchanged", 0, 5, 6'd0, 4'd8, '0);
    check_outs("R9 outputs unchanged");

    // R10 out of range
    access("R10 read idx 9", 0, 9, 6'd0, 4'd8, '0);
    access("R10 write idx 15", 1, 15, 6'd0, 4'd8, '1);
    check_outs("R10 outputs unchanged");

    repeat (3) @(negedge clk);
    check("R11 all responses seen", 256'(exp_q.size()), 256'(0));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule